// File: doc/BRIEF.md
# Buffered Serial Port with Clear-to-Send / Ready-to-Send Pacing

This block is an asynchronous serial transceiver. It sends and receives 8N1 frames and keeps a queue in each direction. The host hands bytes to it over a valid/ready stream. Each accepted byte joins the transmit queue, and the serializer sends queued bytes in order whenever it is idle. Bytes recovered by the deserializer wait in the receive queue. The host drains that queue through a second valid/ready stream. A 4-bit status word shows whether each queue is full or empty.

Two control inputs change how the block behaves. When `fifo_en` is low, each queue is limited to a single entry. When `flow_en` is high, a new frame may begin only while the far end holds `cts` high. In the same mode, `rts` drops while the receive queue is full, which asks the far end to pause. A programmable divisor sets the bit rate: one bit lasts 16·(`baud_div`+1) clock cycles.

Back-pressure follows the usual stream rules. A transmit beat is taken on a clock edge where `tx_valid` and `tx_ready` are both high. A beat offered while `tx_ready` is low is discarded, not held. A receive beat is taken on an edge where `rx_valid` and `rx_ready` are both high. Raising `rx_ready` while the receive queue is empty has no effect.

Top module: `uart_fc_core`

## Requirements
- R1: Every transmitted frame is one start bit at 0, then eight data bits with the least significant bit first, then one stop bit at 1. `txd` rests at 1 between frames.
- R2: The transmit queue holds 8 bytes and sends them in arrival order. `tx_ready` is low while the queue is full, and a beat offered then is discarded.
- R3: The receive queue holds 12 bytes. A frame that completes while the queue is full is discarded.
- R4: `rx_valid` is high exactly when the receive queue is not empty, and `rx_data` then shows the oldest byte. When the queue is empty, `rx_data` reads 0 and `rx_ready` changes nothing.
- R5: `flags` bit 0 is transmit-full, bit 1 is transmit-empty, bit 2 is receive-full and bit 3 is receive-empty. Right after reset the value is 4'b1010.
- R6: While `fifo_en` is low, each queue counts as full once it holds one byte.
- R7: While `flow_en` is high, a frame starts only when the synchronized `cts` is high. A frame already under way completes even if `cts` falls during it.
- R8: While `flow_en` is high, `rts` is low exactly when the receive queue is full. While `flow_en` is low, `rts` stays high.
- R9: The receiver samples each bit at its middle. It abandons a start bit if `rxd` has returned high by the half-bit point, and it discards any frame whose stop bit reads 0.
- R10: The start bit on `txd` lasts between 16·(`baud_div`+1)−`baud_div` and 16·(`baud_div`+1) clock cycles, because oversampling ticks come once every `baud_div`+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: full queue depths; 0: single-entry queues |
| flow_en | input | 1 | 1: enable cts gating and rts generation |
| baud_div | input | 16 | Oversampling tick comes every baud_div+1 cycles |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit queue can accept a byte |
| rx_valid | output | 1 | Receive queue holds a byte |
| rx_data | output | 8 | Oldest received byte, 0 when none |
| rx_ready | input | 1 | Host takes the presented byte |
| flags | output | 4 | {rx_empty, rx_full, tx_empty, tx_full} |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| cts | input | 1 | Far end ready to receive (active high) |
| rts | output | 1 | Block ready to receive (active high) |

## Verification
The hardest case to reach from the ports is `cts` falling partway through a frame while another byte waits behind it. That case has to show that the current frame finishes intact and the next one does not start. The bench holds `cts` low while it loads two bytes, then raises `cts` and decodes the line. About sixty cycles into the first frame it drops `cts` again, and it then checks `txd` for hundreds of cycles to confirm that no second start bit appears. Filling the 12-entry receive queue takes the same kind of control. The bench wires `txd` back to `rxd` and keeps the transmit queue topped up until thirteen frames have crossed the line, so the last frame arrives while the receive queue is full.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int OSR           = 16;
  localparam int FLAG_W        = 4;
  localparam int FLAG_TX_FULL  = 0;
  localparam int FLAG_TX_EMPTY = 1;
  localparam int FLAG_RX_FULL  = 2;
  localparam int FLAG_RX_EMPTY = 3;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_t;
endpackage

// File: rtl/uart_fc_baud.sv
module uart_fc_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  // >= keeps the counter from running away if div shrinks mid-count
  assign tick = (cnt >= div);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         single,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_p, rd_p;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cap;
  logic          do_push, do_pop;

  assign cap     = single ? CW'(1) : CW'(DEPTH);
  assign full    = (cnt >= cap);
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = empty ? '0 : mem[rd_p];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_p] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wr_p <= nxt(wr_p);
      if (do_pop)  rd_p <= nxt(rd_p);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
  import uart_fc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       avail,
  input  logic [7:0] din,
  input  logic       cts_ok,
  output logic       take,
  output logic       busy,
  output logic       txd
);
  localparam int TW = $clog2(OSR);

  logic [9:0]    frame;
  logic [3:0]    bitn;
  logic [TW-1:0] tcnt;

  // cts is consulted only here, between frames
  assign take = !busy && avail && cts_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      frame <= '1;
      bitn  <= '0;
      tcnt  <= '0;
    end else if (!busy) begin
      if (take) begin
        busy  <= 1'b1;
        frame <= {1'b1, din, 1'b0};
        txd   <= 1'b0;
        bitn  <= '0;
        tcnt  <= '0;
      end
    end else if (tick) begin
      if (tcnt == TW'(OSR - 1)) begin
        tcnt <= '0;
        if (bitn == 4'd9) begin
          busy <= 1'b0;
        end else begin
          bitn  <= bitn + 1'b1;
          txd   <= frame[1];
          frame <= {1'b1, frame[9:1]};
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
  import uart_fc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       got,
  output logic [7:0] rx_byte
);
  localparam int TW = $clog2(OSR);

  logic          s1, rs;
  rx_state_t     st;
  logic [TW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      rs <= 1'b1;
    end else begin
      s1 <= rxd;
      rs <= s1;
    end
  end

  assign rx_byte = sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      got  <= 1'b0;
    end else begin
      got <= 1'b0;
      case (st)
        RX_IDLE: if (!rs) begin
          st  <= RX_START;
          cnt <= '0;
        end
        RX_START: if (tick) begin
          if (cnt == TW'(OSR / 2 - 1)) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= rs ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (cnt == TW'(OSR - 1)) begin
            cnt <= '0;
            sh  <= {rs, sh[7:1]};
            if (bitn == 3'd7) st <= RX_STOP;
            else              bitn <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (cnt == TW'(OSR - 1)) begin
            cnt <= '0;
            got <= rs;
            st  <= rs ? RX_IDLE : RX_HOLD;
          end else cnt <= cnt + 1'b1;
        end
        // framing error: wait for the line to return high before rearming
        RX_HOLD: if (rs) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_fc_core.sv
module uart_fc_core
  import uart_fc_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 12,
  parameter int DIV_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              flow_en,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              tx_valid,
  input  logic [7:0]        tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  input  logic              rx_ready,
  output logic [FLAG_W-1:0] flags,
  output logic              txd,
  input  logic              rxd,
  input  logic              cts,
  output logic              rts
);
  logic       tick;
  logic       cts_m, cts_s;
  logic       tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0] tx_head, rx_byte;
  logic       tx_take, tx_busy, rx_got;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cts_m <= 1'b0;
      cts_s <= 1'b0;
    end else begin
      cts_m <= cts;
      cts_s <= cts_m;
    end
  end

  uart_fc_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  uart_fc_fifo #(.DEPTH(TX_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .single(!fifo_en),
    .push(tx_valid), .din(tx_data), .pop(tx_take),
    .dout(tx_head), .full(tx_full), .empty(tx_empty)
  );

  uart_fc_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .avail(!tx_empty),
    .din(tx_head), .cts_ok(!flow_en || cts_s),
    .take(tx_take), .busy(tx_busy), .txd(txd)
  );

  uart_fc_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .got(rx_got), .rx_byte(rx_byte)
  );

  uart_fc_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .single(!fifo_en),
    .push(rx_got), .din(rx_byte), .pop(rx_ready),
    .dout(rx_data), .full(rx_full), .empty(rx_empty)
  );

  assign tx_ready = !tx_full;
  assign rx_valid = !rx_empty;
  assign rts      = !(flow_en && rx_full);

  always_comb begin
    flags                = '0;
    flags[FLAG_TX_FULL]  = tx_full;
    flags[FLAG_TX_EMPTY] = tx_empty;
    flags[FLAG_RX_FULL]  = rx_full;
    flags[FLAG_RX_EMPTY] = rx_empty;
  end
endmodule

// File: rtl/uart_fc_checker.sv
module uart_fc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic       flow_en,
  input logic       cts_s,
  input logic       tx_start,
  input logic       tx_busy,
  input logic       txd,
  input logic       rts,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic [3:0] flags
);
  a_r5_tx_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags[0] && flags[1]));
  a_r5_rx_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags[2] && flags[3]));
  a_r6_depth_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !flags[1]) |-> flags[0]);
  a_r7_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (!flow_en || cts_s));
  a_r8_rts_full: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && flags[2]) |-> !rts);
  a_r8_rts_open: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_en |-> rts);
  a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> (rx_data == 8'h00));
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !txd);
endmodule

bind uart_fc_core uart_fc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flow_en(flow_en),
  .cts_s(cts_s), .tx_start(tx_take), .tx_busy(tx_busy), .txd(txd),
  .rts(rts), .rx_valid(rx_valid), .rx_data(rx_data), .flags(flags)
);

// File: tb/tb_uart_fc_core.sv
module tb_uart_fc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_en = 1'b1, flow_en = 1'b0;
  logic [15:0] baud_div = 16'd0;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_ready, rx_valid, rx_ready = 1'b0;
  logic [7:0]  rx_data;
  logic [3:0]  flags;
  logic        txd, rxd, cts = 1'b1, rts;
  logic        loop = 1'b1, rxd_drv = 1'b1;
  int          checks = 0, fails = 0;

  always #5 clk = ~clk;
  assign rxd = loop ? txd : rxd_drv;

  uart_fc_core dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flow_en(flow_en),
    .baud_div(baud_div), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .flags(flags), .txd(txd), .rxd(rxd),
    .cts(cts), .rts(rts)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic push_byte(input logic [7:0] b, output logic acc);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = b; acc = tx_ready;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_byte(output logic [7:0] b, output logic v);
    @(negedge clk);
    b = rx_data; v = rx_valid; rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  // decode one frame from txd at 16 cycles per bit (baud_div = 0)
  task automatic decode_tx(output logic [7:0] b, output logic ok);
    logic st, sp;
    int   n = 0;
    @(negedge clk);
    while (txd && n < 4000) begin @(negedge clk); n++; end
    repeat (8) @(negedge clk);
    st = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (16) @(negedge clk);
      b[i] = txd;
    end
    repeat (16) @(negedge clk);
    sp = txd;
    ok = (st == 1'b0) && (sp == 1'b1) && (n < 4000);
  endtask

  task automatic wait_rx();
    int n = 0;
    while (!rx_valid && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic drive_rx(input logic [7:0] b, input logic stop);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rxd_drv = f[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk); rxd_drv = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic       acc, v, ok;
    int         lows;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: reset flags, R1 idle line, R8 rts
    check(flags == 4'b1010, "R5 reset flags", flags, 4'b1010);
    check(txd == 1'b1, "R1 idle txd", txd, 1);
    check(rts == 1'b1 && tx_ready && !rx_valid, "R8 reset rts/ready", {rts, tx_ready, rx_valid}, 3'b110);

    // R1/R4: exhaustive sweep of all byte values through loopback
    for (int k = 0; k < 256; k++) begin
      push_byte(8'(k), acc);
      decode_tx(b, ok);
      check(ok && b == 8'(k), "R1 frame", {ok, b}, {1'b1, 8'(k)});
      wait_rx();
      pop_byte(b, v);
      check(v && b == 8'(k), "R4 rx byte", {v, b}, {1'b1, 8'(k)});
    end

    // R2: transmit depth 8, overflow dropped, order kept
    flow_en = 1'b1; cts = 1'b0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      push_byte(8'(8'h10 + i), acc);
      check(acc == (i < 8), "R2 tx accept", acc, (i < 8));
    end
    check(flags[0] == 1'b1 && !tx_ready, "R2 tx full", {flags[0], tx_ready}, 2'b10);
    check(flags[1] == 1'b0, "R5 tx not empty", flags[1], 0);
    cts = 1'b1;
    repeat (8 * 160 + 300) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      pop_byte(b, v);
      check(v && b == 8'(8'h10 + i), "R2 tx order", b, 8'h10 + i);
    end
    pop_byte(b, v);
    check(!v && b == 8'h00, "R4 empty read zero", {v, b}, 0);
    check(flags == 4'b1010, "R4 empty read no change", flags, 4'b1010);

    // R3/R8: receive depth 12, 13th frame dropped, rts low when full
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      push_byte(8'(8'h40 + i), acc);
    end
    repeat (8 * 160 + 400) @(negedge clk);
    check(flags[2] == 1'b1 && flags[1] == 1'b1, "R3 rx full", flags, 4'b0110);
    check(rts == 1'b0, "R8 rts low when full", rts, 0);
    for (int i = 0; i < 12; i++) begin
      pop_byte(b, v);
      check(v && b == 8'(8'h40 + i), "R3 rx order", b, 8'h40 + i);
    end
    pop_byte(b, v);
    check(!v, "R3 overflow frame dropped", {v, b}, 0);
    check(rts == 1'b1, "R8 rts high again", rts, 1);

    // R7: cts drops mid-frame; current frame finishes, next waits
    cts = 1'b0;
    repeat (5) @(negedge clk);
    push_byte(8'hC3, acc);
    push_byte(8'h5A, acc);
    fork
      decode_tx(b, ok);
      begin cts = 1'b1; repeat (60) @(negedge clk); cts = 1'b0; end
    join
    check(ok && b == 8'hC3, "R7 frame completes", b, 8'hC3);
    lows = 0;
    repeat (400) begin @(negedge clk); if (!txd) lows++; end
    check(lows == 0, "R7 held while cts low", lows, 0);
    check(flags[1] == 1'b0, "R7 byte still queued", flags[1], 0);
    fork
      decode_tx(b, ok);
      cts = 1'b1;
    join
    check(ok && b == 8'h5A, "R7 resumes", b, 8'h5A);
    wait_rx();
    pop_byte(b, v);
    check(v && b == 8'hC3, "R7 rx first", b, 8'hC3);
    wait_rx();
    pop_byte(b, v);
    check(v && b == 8'h5A, "R7 rx second", b, 8'h5A);

    // R6: single-entry queues
    fifo_en = 1'b0; cts = 1'b0;
    repeat (5) @(negedge clk);
    push_byte(8'h77, acc);
    check(acc && flags[0] == 1'b1, "R6 tx full at one", {acc, flags[0]}, 2'b11);
    push_byte(8'h88, acc);
    check(!acc, "R6 second tx dropped", acc, 0);
    cts = 1'b1;
    repeat (400) @(negedge clk);
    check(flags[2] == 1'b1 && flags[1] == 1'b1, "R6 rx full at one", flags, 4'b0110);
    push_byte(8'h99, acc);
    repeat (400) @(negedge clk);
    pop_byte(b, v);
    check(v && b == 8'h77, "R6 rx holds first", b, 8'h77);
    pop_byte(b, v);
    check(!v, "R6 later frames dropped", {v, b}, 0);
    fifo_en = 1'b1; flow_en = 1'b0;

    // R9: short glitch, bad stop bit, then a good frame on a driven line
    loop = 1'b0;
    @(negedge clk); rxd_drv = 1'b0;
    repeat (5) @(negedge clk); rxd_drv = 1'b1;
    repeat (300) @(negedge clk);
    check(!rx_valid, "R9 glitch rejected", rx_valid, 0);
    drive_rx(8'hA5, 1'b0);
    repeat (100) @(negedge clk);
    check(!rx_valid, "R9 bad stop dropped", rx_valid, 0);
    drive_rx(8'h3C, 1'b1);
    wait_rx();
    pop_byte(b, v);
    check(v && b == 8'h3C, "R9 good frame", b, 8'h3C);
    loop = 1'b1;

    // R10: start bit width with divisor 3
    baud_div = 16'd3;
    repeat (5) @(negedge clk);
    push_byte(8'h01, acc);
    lows = 0;
    while (txd && lows < 200) begin @(negedge clk); lows++; end
    lows = 0;
    while (!txd && lows < 200) begin @(negedge clk); lows++; end
    check(lows >= 61 && lows <= 64, "R10 start bit width", lows, 64);
    repeat (800) @(negedge clk);
    pop_byte(b, v);
    check(v && b == 8'h01, "R10 loopback at divisor 3", b, 8'h01);
    baud_div = 16'd0;

    summary();
    $finish;
  end
endmodule